// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block drives the SDRAM command pins while a memory controller is being brought up after power-on. It first holds the SDRAM bus idle for a programmable stretch of time. After that it turns byte-sized host writes into a fixed address window into single SDRAM commands. The window has two halves, one per chip-select area. The write data is never used. The control input `mrset` decides what a window write becomes. When it is low, the write issues a precharge-all-banks command. When it is high, the write issues a mode-register-set command, and the SDRAM address bus carries a mode word taken from the write's offset inside the window.

A refresh request input makes the block issue auto-refresh commands to both areas. The block counts the auto-refreshes that follow the most recent precharge-all. It raises a sticky `init_done` flag only when three things have happened in this order: a precharge-all, at least `MIN_REFRESH` auto-refreshes, and then a legal mode-register-set. The data bus width (32 or 64 bit) is a parameter. It sets how far the window offset is shifted to form the mode word.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cs_n` is 2'b11, `sd_ras_n`, `sd_cas_n` and `sd_we_n` are 1, `init_done` is 0 and `host_ready` is 0.
- R2: For the first `IDLE_US*CLK_MHZ` clock cycles after reset is released, `host_ready` stays 0 and no command appears on the pins, even if host writes or refresh requests are present. From that cycle on, `host_ready` is 1 whenever `ref_tick` is 0.
- R3: A write to `WIN_BASE + X` with X below 0x40000 addresses area 2, which is driven by `sd_cs_n[0]`. A write to `WIN_BASE + 0x40000 + X` addresses area 3, which is driven by `sd_cs_n[1]`. Each PALL or MRS command selects exactly one area. Addresses outside the window, and any `host_size` other than 0 (byte), produce no command.
- R4: With `mrset`=0, an accepted window write puts a precharge-all on the pins for the following cycle: RAS=0, CAS=1, WE=0, with `sd_addr` having only bit `PALL_BIT` (10) set. The offset is ignored.
- R5: With `mrset`=1, an accepted legal window write puts a mode-register-set on the pins for the following cycle: RAS=0, CAS=0, WE=0, with `sd_addr` = X>>2 on a 32-bit bus or X>>3 on a 64-bit bus. For example, X=0x48 gives 0x12, X=0xCC gives 0x33, and X=0x8C gives 0x23.
- R6: A mode word is legal only if the bits shifted out are zero, A[2:0] is 2 (burst 4) or 3 (burst 8), A3 is 0 (sequential wrap), A[6:4] is 1, 2 or 3 (CAS latency), and all bits above A6 are zero. An illegal mode write is accepted but produces no command.
- R7: When `ref_tick` is 1 after the idle wait, the next cycle carries an auto-refresh to both areas: `sd_cs_n`=2'b00, RAS=0, CAS=0, WE=1, `sd_addr`=0. While `ref_tick` is 1, `host_ready` is 0, so the refresh takes priority over a pending host write.
- R8: Only auto-refreshes issued after the most recent precharge-all count. A new precharge-all restarts the count. A mode-register-set issued with fewer than `MIN_REFRESH` (8) counted refreshes, or issued before any precharge-all, leaves `init_done` at 0.
- R9: `init_done` rises in the same cycle that the completing mode-register-set appears on the pins. It then stays 1 until reset, whatever commands follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host write request |
| host_addr | input | 32 | Host write address |
| host_size | input | 2 | Access size, 0 = byte |
| host_ready | output | 1 | Host write accepted at the clock edge when valid and ready are both 1 |
| mrset | input | 1 | 0: window write issues precharge-all; 1: mode-register-set |
| ref_tick | input | 1 | Request one auto-refresh command |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | SD_AW | SDRAM address bus |
| init_done | output | 1 | Initialization sequence completed |

## Verification
Some properties are checked on every cycle: the bus stays quiet before the idle wait ends, a precharge-all carries exactly the A10 pattern, a mode word always decodes to a supported burst length, wrap type and CAS latency, each PALL or MRS selects a single area, and a refresh request is followed by an auto-refresh. The flag `init_done` is also checked every cycle: it must be sticky and must rise only together with a mode-register-set. Other behaviour depends on a history of several commands, and only the bench scenarios show it. These are whether refresh counting starts at the latest precharge-all, whether refreshes before any precharge-all are discarded, the exact threshold of eight, the mapping from offset to mode word for each listed setting, and the rejection of odd sizes, foreign addresses and illegal mode words.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_PALL = 2'd1,
      CMD_MRS  = 2'd2,
      CMD_AREF = 2'd3
   } sd_cmd_e;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_pins_t;

   // width of the offset field inside one area of the window
   localparam int OFF_W = 18;

   function automatic sd_pins_t cmd_pins(sd_cmd_e c);
      sd_pins_t p;
      case (c)
         CMD_PALL: p = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         CMD_MRS:  p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
         CMD_AREF: p = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         default:  p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/sdram_init_idle_timer.sv
module sdram_init_idle_timer #(
   parameter int CYCLES = 25000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == LIMIT);
endmodule

// File: rtl/sdram_init_decode.sv
module sdram_init_decode
   import sdram_init_pkg::*;
#(
   parameter logic [31:0] WIN_BASE = 32'hFF90_0000,
   parameter bit          BUS64    = 1'b0,
   parameter int          SD_AW    = 13
) (
   input  logic [31:0]      addr,
   input  logic [1:0]       size,
   output logic             hit,
   output logic             area3,
   output logic             byte_ok,
   output logic             mode_ok,
   output logic [SD_AW-1:0] mode_addr
);
   logic [OFF_W-1:0] off;
   logic [OFF_W-1:0] word;
   logic             low_zero;

   assign off     = addr[OFF_W-1:0];
   assign hit     = (addr[31:OFF_W+1] == WIN_BASE[31:OFF_W+1]);
   assign area3   = addr[OFF_W];
   assign byte_ok = (size == 2'd0);

   generate
      if (BUS64) begin : g_bus64
         assign word     = {3'b000, off[OFF_W-1:3]};
         assign low_zero = (off[2:0] == 3'b000);
      end else begin : g_bus32
         assign word     = {2'b00, off[OFF_W-1:2]};
         assign low_zero = (off[1:0] == 2'b00);
      end
   endgenerate

   always_comb begin
      mode_ok = low_zero
             && (word[OFF_W-1:7] == '0)
             && (word[2:1] == 2'b01)      // burst 4 or 8
             && !word[3]                  // sequential wrap
             && !word[6]
             && (word[5:4] != 2'b00);     // latency 1..3
   end

   assign mode_addr = SD_AW'(word);
endmodule

// File: rtl/sdram_init_tracker.sv
module sdram_init_tracker
   import sdram_init_pkg::*;
#(
   parameter int MIN_REFRESH = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  sd_cmd_e cmd,
   output logic    init_done
);
   localparam int RCW = $clog2(MIN_REFRESH + 1);
   localparam logic [RCW-1:0] RLIM = RCW'(MIN_REFRESH);

   typedef enum logic [1:0] {PH_PRE, PH_REF, PH_DONE} phase_e;

   phase_e        phase;
   logic [RCW-1:0] rcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_PRE;
         rcnt  <= '0;
      end else begin
         case (phase)
            PH_PRE: begin
               if (cmd == CMD_PALL) begin
                  phase <= PH_REF;
                  rcnt  <= '0;
               end
            end
            PH_REF: begin
               if (cmd == CMD_PALL) begin
                  rcnt <= '0;
               end else if (cmd == CMD_AREF) begin
                  if (rcnt != RLIM) rcnt <= rcnt + 1'b1;
               end else if (cmd == CMD_MRS && rcnt == RLIM) begin
                  phase <= PH_DONE;
               end
            end
            default: phase <= PH_DONE;
         endcase
      end
   end

   assign init_done = (phase == PH_DONE);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int          CLK_MHZ     = 125,
   parameter int          IDLE_US     = 200,
   parameter bit          BUS64       = 1'b0,
   parameter int          SD_AW       = 13,
   parameter int          MIN_REFRESH = 8,
   parameter int          PALL_BIT    = 10,
   parameter logic [31:0] WIN_BASE    = 32'hFF90_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_valid,
   input  logic [31:0]      host_addr,
   input  logic [1:0]       host_size,
   output logic             host_ready,
   input  logic             mrset,
   input  logic             ref_tick,
   output logic [1:0]       sd_cs_n,
   output logic             sd_ras_n,
   output logic             sd_cas_n,
   output logic             sd_we_n,
   output logic [SD_AW-1:0] sd_addr,
   output logic             init_done
);
   localparam int IDLE_CYCLES = IDLE_US * CLK_MHZ;
   localparam logic [SD_AW-1:0] PALL_WORD = SD_AW'(1) << PALL_BIT;

   generate
      if (SD_AW < 11) begin : g_bad_aw
         $error("SD_AW must be at least 11");
      end
      if (PALL_BIT >= SD_AW) begin : g_bad_pall
         $error("PALL_BIT must lie inside the address bus");
      end
      if (IDLE_CYCLES < 1) begin : g_bad_idle
         $error("idle wait must be at least one cycle");
      end
      if (MIN_REFRESH < 1) begin : g_bad_ref
         $error("MIN_REFRESH must be at least one");
      end
      if (WIN_BASE[OFF_W:0] != '0) begin : g_bad_base
         $error("WIN_BASE must be aligned to the two-area window");
      end
   endgenerate

   logic             idle_done;
   logic             hit, area3, byte_ok, mode_ok;
   logic [SD_AW-1:0] mode_addr;
   sd_cmd_e          nxt_cmd;
   logic [1:0]       nxt_cs;
   logic [SD_AW-1:0] nxt_addr;
   sd_pins_t         nxt_pins;
   logic             accept;

   sdram_init_idle_timer #(.CYCLES(IDLE_CYCLES)) u_idle (
      .clk  (clk),
      .rst_n(rst_n),
      .done (idle_done)
   );

   sdram_init_decode #(
      .WIN_BASE(WIN_BASE),
      .BUS64   (BUS64),
      .SD_AW   (SD_AW)
   ) u_dec (
      .addr     (host_addr),
      .size     (host_size),
      .hit      (hit),
      .area3    (area3),
      .byte_ok  (byte_ok),
      .mode_ok  (mode_ok),
      .mode_addr(mode_addr)
   );

   sdram_init_tracker #(.MIN_REFRESH(MIN_REFRESH)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (nxt_cmd),
      .init_done(init_done)
   );

   assign host_ready = idle_done && !ref_tick;
   assign accept     = host_valid && host_ready;

   always_comb begin
      nxt_cmd = CMD_NOP;
      if (idle_done && ref_tick) begin
         nxt_cmd = CMD_AREF;
      end else if (accept && hit && byte_ok) begin
         if (!mrset)       nxt_cmd = CMD_PALL;
         else if (mode_ok) nxt_cmd = CMD_MRS;
      end
   end

   always_comb begin
      nxt_pins = cmd_pins(nxt_cmd);
      case (nxt_cmd)
         CMD_AREF: begin nxt_cs = 2'b00; nxt_addr = '0; end
         CMD_PALL: begin nxt_cs = area3 ? 2'b01 : 2'b10; nxt_addr = PALL_WORD; end
         CMD_MRS:  begin nxt_cs = area3 ? 2'b01 : 2'b10; nxt_addr = mode_addr; end
         default:  begin nxt_cs = 2'b11; nxt_addr = '0; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_cs_n  <= 2'b11;
         sd_ras_n <= 1'b1;
         sd_cas_n <= 1'b1;
         sd_we_n  <= 1'b1;
         sd_addr  <= '0;
      end else begin
         sd_cs_n  <= nxt_cs;
         sd_ras_n <= nxt_pins.ras_n;
         sd_cas_n <= nxt_pins.cas_n;
         sd_we_n  <= nxt_pins.we_n;
         sd_addr  <= nxt_addr;
      end
   end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
   parameter int SD_AW    = 13,
   parameter int PALL_BIT = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idle_done,
   input logic             host_ready,
   input logic             ref_tick,
   input logic [1:0]       sd_cs_n,
   input logic             sd_ras_n,
   input logic             sd_cas_n,
   input logic             sd_we_n,
   input logic [SD_AW-1:0] sd_addr,
   input logic             init_done
);
   localparam logic [SD_AW-1:0] PALL_WORD = SD_AW'(1) << PALL_BIT;

   logic is_pall, is_mrs;
   assign is_pall = !sd_ras_n && sd_cas_n && !sd_we_n;
   assign is_mrs  = !sd_ras_n && !sd_cas_n && !sd_we_n;

   // R2
   quiet_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_done |=> (sd_cs_n == 2'b11));

   // R2
   ready_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> idle_done);

   // R7
   aref_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_done && ref_tick) |=> (sd_cs_n == 2'b00 && !sd_ras_n && !sd_cas_n && sd_we_n));

   // R4
   pall_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pall |-> (sd_addr == PALL_WORD));

   // R3
   one_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pall || is_mrs) |-> ($countones(~sd_cs_n) == 1));

   // R6
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (sd_addr[2:1] == 2'b01 && !sd_addr[3] && !sd_addr[6]
                  && sd_addr[5:4] != 2'b00 && (sd_addr >> 7) == '0));

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R9
   done_with_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> is_mrs);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
   .SD_AW   (SD_AW),
   .PALL_BIT(PALL_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .idle_done (idle_done),
   .host_ready(host_ready),
   .ref_tick  (ref_tick),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_addr   (sd_addr),
   .init_done (init_done)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
   localparam int AW       = 13;
   localparam int IDLE_US  = 1;
   localparam int CLK_MHZ  = 125;
   localparam int N_IDLE   = IDLE_US * CLK_MHZ;

   // pin codes {ras,cas,we}
   localparam logic [2:0] P_NOP  = 3'b111;
   localparam logic [2:0] P_PALL = 3'b010;
   localparam logic [2:0] P_MRS  = 3'b000;
   localparam logic [2:0] P_AREF = 3'b001;
   localparam logic [AW-1:0] A10 = 13'h400;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_valid;
   logic [31:0]   host_addr;
   logic [1:0]    host_size;
   logic          host_ready;
   logic          mrset;
   logic          ref_tick;
   logic [1:0]    sd_cs_n;
   logic          sd_ras_n, sd_cas_n, sd_we_n;
   logic [AW-1:0] sd_addr;
   logic          init_done;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   sdram_init_seq #(
      .CLK_MHZ(CLK_MHZ),
      .IDLE_US(IDLE_US),
      .SD_AW  (AW)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_valid(host_valid),
      .host_addr (host_addr),
      .host_size (host_size),
      .host_ready(host_ready),
      .mrset     (mrset),
      .ref_tick  (ref_tick),
      .sd_cs_n   (sd_cs_n),
      .sd_ras_n  (sd_ras_n),
      .sd_cas_n  (sd_cas_n),
      .sd_we_n   (sd_we_n),
      .sd_addr   (sd_addr),
      .init_done (init_done)
   );

   typedef struct packed {
      logic          ms;
      logic [1:0]    sz;
      logic [31:0]   ad;
      logic [2:0]    pins;
      logic [1:0]    cs;
      logic [AW-1:0] a;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 2'd0, 32'hFF90_0000, P_PALL, 2'b10, A10},   // R4 area 2
      '{1'b0, 2'd0, 32'hFF94_0000, P_PALL, 2'b01, A10},   // R3 area 3
      '{1'b1, 2'd0, 32'hFF90_0048, P_MRS,  2'b10, 13'h12},// R5 BL4 CL1
      '{1'b1, 2'd0, 32'hFF90_00CC, P_MRS,  2'b10, 13'h33},// R5 BL8 CL3
      '{1'b1, 2'd0, 32'hFF94_008C, P_MRS,  2'b01, 13'h23},// R5 area 3
      '{1'b1, 2'd2, 32'hFF90_0048, P_NOP,  2'b11, 13'h0}, // R3 not byte
      '{1'b1, 2'd0, 32'hFF90_0108, P_NOP,  2'b11, 13'h0}, // R6 CL 4
      '{1'b1, 2'd0, 32'hFF90_0050, P_NOP,  2'b11, 13'h0}, // R6 BL code 4
      '{1'b1, 2'd0, 32'hFF90_0068, P_NOP,  2'b11, 13'h0}, // R6 interleave
      '{1'b1, 2'd0, 32'hFF90_004A, P_NOP,  2'b11, 13'h0}, // R6 unaligned
      '{1'b1, 2'd0, 32'hFF80_0048, P_NOP,  2'b11, 13'h0}, // R3 outside
      '{1'b0, 2'd0, 32'hFF90_0048, P_PALL, 2'b10, A10}    // R4 offset ignored
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_pins(input string req, input logic [2:0] p,
                             input logic [1:0] cs, input logic [AW-1:0] a);
      logic [2:0] ap;
      bit ok;
      ap = {sd_ras_n, sd_cas_n, sd_we_n};
      ok = (ap == p) && (sd_cs_n == cs) && ((cs == 2'b11) || (sd_addr == a));
      check(ok, req, {ap, sd_cs_n, sd_addr}, {p, cs, a});
   endtask

   // called at a negedge; returns at the negedge where the command is visible
   task automatic wr(input logic [31:0] ad, input logic [1:0] sz, input logic ms);
      host_addr  = ad;
      host_size  = sz;
      mrset      = ms;
      host_valid = 1'b1;
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   task automatic refresh(input int n);
      for (int i = 0; i < n; i++) begin
         ref_tick = 1'b1;
         #1;
         check(!host_ready, "R7 ready low", host_ready, 0);
         @(negedge clk);
         ref_tick = 1'b0;
         check_pins("R7 auto-refresh", P_AREF, 2'b00, '0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      bit quiet;
      rst_n = 1'b0; host_valid = 1'b0; host_addr = '0; host_size = '0;
      mrset = 1'b0; ref_tick = 1'b0;
      repeat (3) @(negedge clk);
      check_pins("R1 reset pins", P_NOP, 2'b11, '0);
      check(!init_done && !host_ready, "R1 reset flags", {init_done, host_ready}, 0);

      // R2: requests during idle wait are held off
      rst_n = 1'b1;
      host_addr = 32'hFF90_0000; host_size = 2'd0; mrset = 1'b0;
      host_valid = 1'b1; ref_tick = 1'b1;
      quiet = 1'b1;
      for (int k = 1; k < N_IDLE; k++) begin
         @(negedge clk);
         if (host_ready || sd_cs_n != 2'b11) quiet = 1'b0;
      end
      host_valid = 1'b0; ref_tick = 1'b0;
      check(quiet, "R2 quiet during idle", quiet, 1);
      @(negedge clk);
      check(host_ready, "R2 ready at idle end", host_ready, 1);
      check_pins("R2 no command at idle end", P_NOP, 2'b11, '0);

      // refreshes before any precharge-all (not counted, R8)
      refresh(8);

      for (int v = 0; v < NV; v++) begin
         wr(TBL[v].ad, TBL[v].sz, TBL[v].ms);
         check_pins($sformatf("R3-6 vector %0d", v), TBL[v].pins, TBL[v].cs, TBL[v].a);
      end
      check(!init_done, "R8 early refreshes ignored", init_done, 0);

      refresh(7);
      wr(32'hFF90_0088, 2'd0, 1'b1);
      check_pins("R5 MRS CL2", P_MRS, 2'b10, 13'h22);
      check(!init_done, "R8 seven refreshes short", init_done, 0);

      refresh(1);
      wr(32'hFF94_0000, 2'd0, 1'b0);
      wr(32'hFF90_0088, 2'd0, 1'b1);
      check(!init_done, "R8 precharge restarts count", init_done, 0);

      refresh(8);
      wr(32'hFF90_008C, 2'd0, 1'b1);
      check_pins("R9 completing MRS", P_MRS, 2'b10, 13'h23);
      check(init_done, "R9 done with MRS", init_done, 1);

      wr(32'hFF90_0000, 2'd0, 1'b0);
      check_pins("R4 PALL after done", P_PALL, 2'b10, A10);
      check(init_done, "R9 done sticky", init_done, 1);

      // R7 priority over a pending write
      host_addr = 32'hFF94_0048; host_size = 2'd0; mrset = 1'b1;
      host_valid = 1'b1; ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
      check_pins("R7 refresh wins", P_AREF, 2'b00, '0);
      @(negedge clk);
      host_valid = 1'b0;
      check_pins("R7 write after refresh", P_MRS, 2'b01, 13'h12);

      rst_n = 1'b0;
      @(negedge clk);
      check(!init_done, "R1 reset clears done", init_done, 1'b0);
      check_pins("R1 reset pins again", P_NOP, 2'b11, '0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule